// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block watches the supply of a battery-backed static memory and decides, one clock at a time, whether the memory may be touched. Three supply comparator flags arrive already synchronised. The first says the supply is above the battery switch-over level (about 3.0 V). The second says it is above the protect trip (4.25 V). The third says it is above the full-operation level (4.5 V). Every flag passes through a stability filter before the state machine acts on it.

The state machine has five states. ST_OFF is the state before supply is first seen. ST_BACKUP means the battery feeds the memory. ST_POWERUP_HOLD is the recovery hold-off. ST_ACTIVE means normal access. ST_PROTECT covers a brown-out while the supply is still above switch-over. The named transitions are:
- OFF→POWERUP_HOLD and BACKUP→POWERUP_HOLD, on the switch flag rising.
- POWERUP_HOLD→ACTIVE, after the hold-off expires with the supply at full level.
- POWERUP_HOLD→BACKUP, ACTIVE→BACKUP and PROTECT→BACKUP, on the switch flag falling.
- ACTIVE→PROTECT, on the trip flag falling.
- PROTECT→POWERUP_HOLD, on the full-level flag rising.

The `wp_isolate` output is high in every state except ACTIVE. While it is high, the surrounding logic holds all memory strobes inactive and the data pins at high impedance.

Each memory lane has two cells, A and B. In BACKUP, a per-lane selector picks the cell to use. On every entry into the hold-off, each lane's cell flags are sampled. A lane whose two cells are both weak raises its access inhibit, and the inhibit holds until the next such entry.

Top module: `pfs_supervisor`

## Requirements
- R1: After reset the block is in ST_OFF: `wp_isolate`=1, `bat_connect`=0, `bat_sel_b`=0 and `access_inhibit`=0. The battery stays disconnected in ST_OFF whatever the switch flag does, until that flag has once been seen high.
- R2: A supply flag counts as changed only after it has held its new value for STABLE consecutive sampled clocks. A pulse shorter than STABLE clocks has no effect on any output.
- R3: `wp_isolate` is high in every state but ST_ACTIVE. When `vdd_above_protect` is first sampled low in ST_ACTIVE (switch flag still high), `wp_isolate` rises STABLE+1 clock edges later, and the state becomes ST_PROTECT.
- R4: A low switch flag sends any state other than ST_OFF to ST_BACKUP, and this takes priority over the trip flag when both fall on the same clock. `bat_connect`=1 only in ST_BACKUP.
- R5: A high switch flag moves ST_OFF and ST_BACKUP to ST_POWERUP_HOLD, STABLE+1 edges after the flag was first sampled high. In ST_POWERUP_HOLD, `bat_connect`=0 and `wp_isolate`=1.
- R6: ST_POWERUP_HOLD goes to ST_ACTIVE only after the full-level and trip flags are filtered high and the full-level flag has stayed filtered high for HOLD_CYCLES+1 clocks in the state. The count restarts whenever the filtered full-level flag is low. If both flags rise on the clock the state is entered, `wp_isolate` falls STABLE+HOLD_CYCLES+2 edges after the flags were first sampled high.
- R7: Hysteresis. In ST_ACTIVE a low full-level flag alone (trip flag high) keeps the state. ST_PROTECT returns to ST_POWERUP_HOLD only on the full-level flag, never on the trip flag alone.
- R8: On every clock in ST_BACKUP, lane i sets `bat_sel_b[i]` (0 = cell A, 1 = cell B) one edge later. The rules are: A if only A is healthy; B if only B is healthy; otherwise A when `bat_a_ge_b[i]`=1 and B when it is 0.
- R9: Outside ST_BACKUP, `bat_sel_b` keeps its value whatever the cell flags do.
- R10: On the edge that enters ST_POWERUP_HOLD, `access_inhibit[i]` is loaded with 1 if both `bat_a_ok[i]` and `bat_b_ok[i]` are 0, and with 0 otherwise. At all other times it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_above_switch | input | 1 | Supply above the battery switch-over level |
| vdd_above_protect | input | 1 | Supply above the write-protect trip |
| vdd_above_run | input | 1 | Supply above the full-operation level |
| bat_a_ok | input | LANES | Per lane, cell A above its minimum |
| bat_b_ok | input | LANES | Per lane, cell B above its minimum |
| bat_a_ge_b | input | LANES | Per lane, cell A voltage not below cell B |
| wp_isolate | output | 1 | Write protect and bus isolate |
| bat_connect | output | 1 | Connect battery path to the memory |
| bat_sel_b | output | LANES | Per lane backup cell select, 1 = cell B |
| access_inhibit | output | LANES | Per lane low-battery access inhibit |

## Verification
Two functions can meet on one clock: the brown-out protect and the battery switch-over. The bench drops the trip flag and the switch flag on the same falling edge while the block is ACTIVE. STABLE+1 edges later it expects the battery to be connected, with the state in BACKUP and not in PROTECT. A second overlap is the hold-off entry and the inhibit sample, which share one edge. The bench changes cell health in BACKUP and before recovery from PROTECT, then checks that the inhibit moves on exactly the entry edge and at no other time. A sweep over all eight cell-flag combinations per lane checks the select rule arithmetically.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [2:0] {
        ST_OFF          = 3'd0,
        ST_BACKUP       = 3'd1,
        ST_POWERUP_HOLD = 3'd2,
        ST_ACTIVE       = 3'd3,
        ST_PROTECT      = 3'd4
    } pfs_state_e;

    localparam int unsigned FLAG_SW  = 0;
    localparam int unsigned FLAG_LO  = 1;
    localparam int unsigned FLAG_HI  = 2;
    localparam int unsigned NUM_FLAG = 3;
endpackage

// File: rtl/pfs_debounce.sv
module pfs_debounce #(
    parameter int unsigned STABLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int unsigned CW = (STABLE < 2) ? 1 : $clog2(STABLE);
    localparam logic [CW-1:0] CNT_LAST = CW'(STABLE - 1);

    logic [CW-1:0] run_cnt;

    // filt follows raw once raw has differed for STABLE sampled clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt    <= 1'b0;
            run_cnt <= '0;
        end else if (raw == filt) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            filt    <= raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
    import pfs_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_f,
    input  logic lo_f,
    input  logic hi_f,
    output logic check_stb,
    output logic protect,
    output logic batt_conn
);
    localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES);

    pfs_state_e    state_q;
    pfs_state_e    state_d;
    logic [HW-1:0] hold_cnt;
    logic          hold_done;

    assign hold_done = (hold_cnt == HOLD_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // recovery hold-off counter: counts only valid-supply clocks in the hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (state_q == ST_POWERUP_HOLD && hi_f) begin
            if (!hold_done) begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end else begin
            hold_cnt <= '0;
        end
    end

    // transitions: the lowest supply condition wins
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (sw_f) state_d = ST_POWERUP_HOLD;
            end
            ST_BACKUP: begin
                if (sw_f) state_d = ST_POWERUP_HOLD;
            end
            ST_POWERUP_HOLD: begin
                if (!sw_f)                          state_d = ST_BACKUP;
                else if (hi_f && lo_f && hold_done) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!sw_f)      state_d = ST_BACKUP;
                else if (!lo_f) state_d = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (!sw_f)     state_d = ST_BACKUP;
                else if (hi_f) state_d = ST_POWERUP_HOLD;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        protect   = (state_q != ST_ACTIVE);
        batt_conn = (state_q == ST_BACKUP);
        check_stb = (state_d == ST_POWERUP_HOLD) && (state_q != ST_POWERUP_HOLD);
    end
endmodule

// File: rtl/pfs_lane.sv
module pfs_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic in_backup,
    input  logic check_stb,
    input  logic a_ok,
    input  logic b_ok,
    input  logic a_ge_b,
    output logic sel_b,
    output logic inhibit
);
    logic pick_b;

    always_comb begin
        if (a_ok && !b_ok)      pick_b = 1'b0;
        else if (b_ok && !a_ok) pick_b = 1'b1;
        else                    pick_b = !a_ge_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_b <= 1'b0;
        end else if (in_backup) begin
            sel_b <= pick_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inhibit <= 1'b0;
        end else if (check_stb) begin
            inhibit <= !a_ok && !b_ok;
        end
    end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
    import pfs_pkg::*;
#(
    parameter int unsigned LANES       = 4,
    parameter int unsigned STABLE      = 8,
    parameter int unsigned HOLD_CYCLES = 6_250_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vdd_above_switch,
    input  logic             vdd_above_protect,
    input  logic             vdd_above_run,
    input  logic [LANES-1:0] bat_a_ok,
    input  logic [LANES-1:0] bat_b_ok,
    input  logic [LANES-1:0] bat_a_ge_b,
    output logic             wp_isolate,
    output logic             bat_connect,
    output logic [LANES-1:0] bat_sel_b,
    output logic [LANES-1:0] access_inhibit
);
    logic [NUM_FLAG-1:0] raw_v;
    logic [NUM_FLAG-1:0] filt_v;
    logic                check_stb;
    logic                batt_conn;

    assign raw_v[FLAG_SW] = vdd_above_switch;
    assign raw_v[FLAG_LO] = vdd_above_protect;
    assign raw_v[FLAG_HI] = vdd_above_run;

    for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
        pfs_debounce #(.STABLE(STABLE)) u_db (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_v[g]),
            .filt (filt_v[g])
        );
    end

    pfs_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_f     (filt_v[FLAG_SW]),
        .lo_f     (filt_v[FLAG_LO]),
        .hi_f     (filt_v[FLAG_HI]),
        .check_stb(check_stb),
        .protect  (wp_isolate),
        .batt_conn(batt_conn)
    );

    assign bat_connect = batt_conn;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pfs_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_backup(batt_conn),
            .check_stb(check_stb),
            .a_ok     (bat_a_ok[l]),
            .b_ok     (bat_b_ok[l]),
            .a_ge_b   (bat_a_ge_b[l]),
            .sel_b    (bat_sel_b[l]),
            .inhibit  (access_inhibit[l])
        );
    end
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
    parameter int unsigned LANES       = 4,
    parameter int unsigned STABLE      = 8,
    parameter int unsigned HOLD_CYCLES = 6_250_000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vdd_above_switch,
    input logic             vdd_above_protect,
    input logic             vdd_above_run,
    input logic             wp_isolate,
    input logic             bat_connect,
    input logic [LANES-1:0] bat_sel_b,
    input logic [LANES-1:0] access_inhibit
);
    localparam int unsigned LW = $clog2(STABLE + 2);
    localparam logic [LW-1:0] LO_SAT = LW'(STABLE + 1);
    localparam int unsigned HW = $clog2(HOLD_CYCLES + 2);
    localparam logic [HW-1:0] HOLD_SAT = HW'(HOLD_CYCLES + 1);

    logic [LW-1:0] lo_run;
    logic [HW-1:0] hold_run;
    logic          seen_sw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run   <= '0;
            hold_run <= '0;
            seen_sw  <= 1'b0;
        end else begin
            if (vdd_above_protect)     lo_run <= '0;
            else if (lo_run != LO_SAT) lo_run <= lo_run + 1'b1;
            if (!(wp_isolate && !bat_connect)) hold_run <= '0;
            else if (hold_run != HOLD_SAT)     hold_run <= hold_run + 1'b1;
            if (vdd_above_switch) seen_sw <= 1'b1;
        end
    end

    assert_no_batt_before_supply_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_sw |-> !bat_connect);

    assert_protect_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_run == LO_SAT) |-> wp_isolate);

    assert_batt_only_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bat_connect |-> wp_isolate);

    assert_holdoff_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wp_isolate) |-> (hold_run == HOLD_SAT));

    assert_active_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wp_isolate) |-> ($past(vdd_above_run) && $past(vdd_above_protect)));

    assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bat_sel_b) |-> $past(bat_connect));

    assert_inhibit_on_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(access_inhibit) |-> (wp_isolate && !bat_connect));
endmodule

bind pfs_supervisor pfs_checker #(
    .LANES      (LANES),
    .STABLE     (STABLE),
    .HOLD_CYCLES(HOLD_CYCLES)
) u_pfs_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .vdd_above_switch (vdd_above_switch),
    .vdd_above_protect(vdd_above_protect),
    .vdd_above_run    (vdd_above_run),
    .wp_isolate       (wp_isolate),
    .bat_connect      (bat_connect),
    .bat_sel_b        (bat_sel_b),
    .access_inhibit   (access_inhibit)
);

// File: tb/pfs_supervisor_bench.sv
`timescale 1ns/1ps
module pfs_supervisor_bench;
    localparam int unsigned LANES = 2;
    localparam int unsigned STB   = 3;
    localparam int unsigned HOLD  = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sw = 1'b0, lo = 1'b0, hi = 1'b0;
    logic [LANES-1:0] a_ok = '0, b_ok = '0, a_ge = '0;
    logic             wp, bconn;
    logic [LANES-1:0] sel, inh;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfs_supervisor #(.LANES(LANES), .STABLE(STB), .HOLD_CYCLES(HOLD)) u_pfs_supervisor (
        .clk(clk), .rst_n(rst_n),
        .vdd_above_switch(sw), .vdd_above_protect(lo), .vdd_above_run(hi),
        .bat_a_ok(a_ok), .bat_b_ok(b_ok), .bat_a_ge_b(a_ge),
        .wp_isolate(wp), .bat_connect(bconn), .bat_sel_b(sel), .access_inhibit(inh)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_sel(input logic a, input logic b, input logic ge);
        if (a && !b)      return 1'b0;
        else if (b && !a) return 1'b1;
        else              return !ge;
    endfunction

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1: reset state and no battery before first supply
        chk("R1 wp", wp, 1); chk("R1 bconn", bconn, 0);
        chk("R1 sel", sel, 0); chk("R1 inh", inh, 0);
        tick(10);
        chk("R1 off no batt", bconn, 0);

        // first power-up: lane0 both cells weak, lane1 healthy
        a_ok = 2'b10; b_ok = 2'b10;
        sw = 1; lo = 1; hi = 1;
        tick(STB);
        chk("R5 not yet", inh, 2'b00);
        tick(1);
        chk("R10 inhibit sampled", inh, 2'b01);
        chk("R5 hold isolated", wp, 1);
        chk("R5 hold no batt", bconn, 0);
        tick(HOLD);
        chk("R6 hold last cycle", wp, 1);
        tick(1);
        chk("R6 active", wp, 0);

        // R2: short glitch on trip flag ignored
        lo = 0; tick(STB - 1); lo = 1;
        tick(STB + 3);
        chk("R2 glitch ignored", wp, 0);

        // R3: brown-out latency
        lo = 0; hi = 0;
        tick(STB);
        chk("R3 before", wp, 0);
        tick(1);
        chk("R3 protect", wp, 1);
        chk("R3 no batt", bconn, 0);

        // R10: cell health change while in PROTECT leaves inhibit
        a_ok = 2'b11;
        tick(4);
        chk("R10 held in protect", inh, 2'b01);

        // R7: trip flag alone does not leave PROTECT
        lo = 1;
        tick(2 * STB + 2);
        chk("R7 protect kept", wp, 1);
        hi = 1;
        tick(STB + 1);
        chk("R10 cleared on check", inh, 2'b00);
        chk("R5 re-hold", wp, 1);
        tick(HOLD);
        chk("R6 re-hold last", wp, 1);
        tick(1);
        chk("R6 re-active", wp, 0);

        // R7: full-level flag dropping alone keeps ACTIVE
        hi = 0;
        tick(STB + 4);
        chk("R7 active kept", wp, 0);

        // R4: switch and trip drop on the same clock -> BACKUP
        sw = 0; lo = 0;
        tick(STB);
        chk("R4 before", bconn, 0);
        tick(1);
        chk("R4 backup batt", bconn, 1);
        chk("R4 backup isolated", wp, 1);

        // R8: sweep all cell-flag combinations per lane
        for (int i = 0; i < 8; i++) begin
            logic [2:0] c0, c1;
            c0 = 3'(i); c1 = 3'(7 - i);
            a_ok = {c1[2], c0[2]}; b_ok = {c1[1], c0[1]}; a_ge = {c1[0], c0[0]};
            tick(1);
            chk("R8 select", sel, {exp_sel(c1[2], c1[1], c1[0]), exp_sel(c0[2], c0[1], c0[0])});
        end

        // restore switch level only: both lanes weak
        a_ok = 2'b00; b_ok = 2'b00; a_ge = 2'b01;
        sw = 1;
        tick(STB + 1);
        chk("R10 both weak", inh, 2'b11);
        chk("R5 batt off", bconn, 0);
        chk("R8 last select", sel, 2'b10);
        a_ok = 2'b11; a_ge = 2'b00;
        tick(3);
        chk("R9 select frozen", sel, 2'b10);
        tick(2 * HOLD);
        chk("R6 waits for full", wp, 1);
        hi = 1; lo = 1;
        tick(STB + HOLD);
        chk("R6 count restart last", wp, 1);
        tick(1);
        chk("R6 count restart active", wp, 0);
        chk("R10 held after hold", inh, 2'b11);
        chk("R9 select still", sel, 2'b10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule